// File: doc/BRIEF.md
# Double-Edge Four-Lane Source-Synchronous Capture

This block receives a parallel source-synchronous stream made of four data lanes, a forwarded clock and a frame marker, all already converted to single-ended logic levels. The forwarded clock is oversampled by a faster system clock. Every level change of the forwarded clock, rising or falling, delivers one new four-bit nibble. Because clock, data and marker all switch together, the lanes are not taken on the detected transition itself. They are taken one system cycle later, once they have settled.

The frame marker is consulted only while the block is waiting for alignment. The first nibble whose transition coincides with a high marker becomes the first nibble of the stream, and after that the marker is not looked at again. Nibbles are gathered four at a time into 16-bit words. Each word is offered to a downstream buffer through a valid/ready handshake. If a word completes while the previous one is still waiting, the new word is discarded and a sticky overflow flag is raised. Dropping the enable input discards any partial word and forces a fresh alignment.

Top module: `ddr_lane_capture`

## Requirements
- R1: Every level change of the forwarded clock, in either direction, captures one nibble from the four lanes. A run of 16 transitions after alignment yields exactly four words.
- R2: Lane and marker values are taken one system cycle after the synchronised transition is detected. Lanes held for at least two system clock cycles after each forwarded transition are therefore captured correctly.
- R3: The forwarded clock level present when reset ends, whether high or low, is taken as the starting level and never counts as a transition.
- R4: Before alignment, transitions whose marker is low are discarded. The first transition with the marker high supplies the first nibble of the stream.
- R5: Once aligned, the marker has no effect. A high marker in the middle of a word neither restarts nor shifts the packing.
- R6: The four nibbles of a word are placed in capture order, with nibble k in bits [4k+3:4k], so the first nibble sits in bits [3:0]. A word stays valid and unchanged until it is accepted with ready high.
- R7: If a word completes while a valid word is pending and ready is low, the completed word is dropped and the overflow flag goes high. The flag then stays high until reset.
- R8: While enable is low, no nibble is captured, the partial word is discarded and alignment is cleared. After enable returns high, capture waits for the next marker.
- R9: After reset, valid and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the forwarded transition rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable; low clears alignment and partial word |
| fwd_clk | input | 1 | Forwarded clock from the source |
| frame_mark | input | 1 | Frame marker, used only for initial alignment |
| lanes | input | 4 | Four data lanes |
| word_ready | input | 1 | Downstream can accept a word |
| word_valid | output | 1 | A packed word is offered |
| word_data | output | 16 | Packed word, first nibble in bits [3:0] |
| overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
The bench builds the block with its default parameters: four lanes, 16-bit words and a two-stage synchroniser, so each word holds four nibbles. It sweeps forwarded half-periods of 2, 3 and 5 system cycles against both starting clock levels. The half-period of 2 reaches the minimum lane hold time. The high starting level, with the marker held high through reset, exposes any false transition at start-up. Separate sequences drive the back-pressure case to make overflow happen, and toggle enable in the middle of a word to force realignment.

// File: rtl/ddrcap_pkg.sv
package ddrcap_pkg;
  localparam int DEF_LANES  = 4;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_SYNC   = 2;

  function automatic int nibbles_per_word(input int word_w, input int lanes);
    return word_w / lanes;
  endfunction
endpackage

// File: rtl/ddrcap_sync.sv
module ddrcap_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  // No reset: the chain must carry the true input level by the end of reset.
  always_ff @(posedge clk) stg[0] <= din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ddrcap_edge.sv
module ddrcap_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic strobe
);
  logic primed;
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      prev   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      primed <= 1'b1;
      prev   <= lvl;
      strobe <= primed && (lvl != prev);
    end
  end
endmodule

// File: rtl/ddrcap_pack.sv
module ddrcap_pack #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              strobe,
  input  logic [LANES-1:0]  nib,
  input  logic              mark,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic              ovf
);
  localparam int NIB   = WORD_W / LANES;
  localparam int CNT_W = (NIB > 1) ? $clog2(NIB) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NIB - 1);

  logic              aligned;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] nxt;
  logic              take;

  assign take = en && strobe && (aligned || mark);

  always_comb begin
    nxt = acc;
    nxt[cnt*LANES +: LANES] = nib;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aligned <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      valid   <= 1'b0;
      data    <= '0;
      ovf     <= 1'b0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (!en) begin
        aligned <= 1'b0;
        cnt     <= '0;
      end else if (take) begin
        aligned <= 1'b1;
        acc     <= nxt;
        if (cnt == LAST) begin
          cnt <= '0;
          if (valid && !ready) begin
            ovf <= 1'b1;
          end else begin
            data  <= nxt;
            valid <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(data));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(valid && !ready));
endmodule

// File: rtl/ddr_lane_capture.sv
module ddr_lane_capture #(
  parameter int LANES  = ddrcap_pkg::DEF_LANES,
  parameter int WORD_W = ddrcap_pkg::DEF_WORD_W,
  parameter int SYNC   = ddrcap_pkg::DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fwd_clk,
  input  logic              frame_mark,
  input  logic [LANES-1:0]  lanes,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              overflow
);
  localparam int SW = LANES + 2;

  logic [SW-1:0]    s_bus;
  logic             s_clk;
  logic             s_mark;
  logic [LANES-1:0] s_lanes;
  logic             strobe;

  ddrcap_sync #(.W(SW), .STAGES(SYNC)) u_sync (
    .clk  (clk),
    .din  ({fwd_clk, frame_mark, lanes}),
    .dout (s_bus)
  );

  assign {s_clk, s_mark, s_lanes} = s_bus;

  ddrcap_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl    (s_clk),
    .strobe (strobe)
  );

  ddrcap_pack #(.LANES(LANES), .WORD_W(WORD_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .strobe (strobe),
    .nib    (s_lanes),
    .mark   (s_mark),
    .ready  (word_ready),
    .valid  (word_valid),
    .data   (word_data),
    .ovf    (overflow)
  );

  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !en && !word_valid |=> !word_valid);
endmodule

// File: tb/ddr_lane_capture_tb.sv
module ddr_lane_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        fwd_clk = 1'b0;
  logic        frame_mark = 1'b0;
  logic [3:0]  lanes = 4'h0;
  logic        word_ready = 1'b1;
  logic        word_valid;
  logic [15:0] word_data;
  logic        overflow;

  int total = 0;
  int bad = 0;
  int got = 0;
  bit done = 1'b0;
  logic [15:0] expq[$];

  always #4 clk = ~clk;

  ddr_lane_capture u_dut (
    .clk(clk), .rst(rst), .en(en), .fwd_clk(fwd_clk), .frame_mark(frame_mark),
    .lanes(lanes), .word_ready(word_ready), .word_valid(word_valid),
    .word_data(word_data), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Word monitor: handshake completes at the next rising edge.
  always @(negedge clk) begin
    if (!rst && word_valid && word_ready) begin
      got++;
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected word", word_data, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(word_data == e, "R6 word content", word_data, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] nib, input logic fs, input int half);
    lanes = nib;
    frame_mark = fs;
    fwd_clk = ~fwd_clk;
    tick(half);
  endtask

  task automatic do_reset(input logic level);
    en = 1'b0; word_ready = 1'b1; fwd_clk = level; frame_mark = 1'b1; lanes = 4'hA;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
    check(word_valid == 1'b0, "R9 valid after reset", word_valid, 0);
    check(overflow == 1'b0, "R9 overflow after reset", overflow, 0);
    expq.delete();
  endtask

  // Aligned stream of 16 nibbles with a second marker mid-word (R1 R2 R3 R4 R5 R6).
  task automatic run_stream(input logic level, input int half, input int seed);
    int start;
    logic [15:0] w;
    do_reset(level);
    en = 1'b1;
    tick(6);
    for (int j = 0; j < 3; j++) send(4'hF, 1'b0, half);
    start = got;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] nib;
      nib = 4'((i * 5 + seed) & 15);
      w[(i % 4) * 4 +: 4] = nib;
      if (i % 4 == 3) expq.push_back(w);
      send(nib, (i == 0 || i == 6), half);
    end
    tick(10);
    check(got - start == 4, "R1 word count", got - start, 4);
    check(expq.size() == 0, "R4 missing words", expq.size(), 0);
  endtask

  initial begin
    automatic int halves[3] = '{2, 3, 5};
    for (int h = 0; h < 3; h++)
      for (int lv = 0; lv < 2; lv++)
        run_stream(lv[0], halves[h], h * 3 + lv);

    // R7: back-pressure leads to a dropped word and a sticky flag.
    begin
      logic [15:0] wa, wc;
      int start;
      do_reset(1'b0);
      en = 1'b1; word_ready = 1'b0;
      tick(4);
      wa = 16'h4321; wc = 16'hC0DE;
      for (int i = 0; i < 4; i++) send(wa[i*4 +: 4], i == 0, 3);
      for (int i = 0; i < 4; i++) send(4'h9, 1'b0, 3);
      tick(6);
      check(overflow == 1'b1, "R7 overflow set", overflow, 1);
      check(word_valid == 1'b1, "R6 valid held", word_valid, 1);
      check(word_data == wa, "R6 data held", word_data, wa);
      start = got;
      expq.push_back(wa);
      word_ready = 1'b1;
      tick(3);
      expq.push_back(wc);
      for (int i = 0; i < 4; i++) send(wc[i*4 +: 4], 1'b0, 3);
      tick(8);
      check(got - start == 2, "R7 dropped word absent", got - start, 2);
      check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    end

    // R8: enable low discards the partial word and forces realignment.
    begin
      logic [15:0] wn;
      int start;
      do_reset(1'b0);
      en = 1'b1;
      tick(4);
      start = got;
      send(4'h1, 1'b1, 3);
      send(4'h2, 1'b0, 3);
      en = 1'b0;
      for (int i = 0; i < 4; i++) send(4'h7, 1'b1, 3);
      tick(6);
      check(got == start && !word_valid, "R8 no capture while disabled", got - start, 0);
      en = 1'b1;
      tick(2);
      send(4'h5, 1'b0, 3);
      send(4'h6, 1'b0, 3);
      wn = 16'hB3E8;
      expq.push_back(wn);
      for (int i = 0; i < 4; i++) send(wn[i*4 +: 4], i == 0, 3);
      tick(8);
      check(got - start == 1, "R8 realigned word count", got - start, 1);
      check(expq.size() == 0, "R8 realigned word seen", expq.size(), 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule